// File: doc/BRIEF.md
# Maskable Interrupt Enable Controller

This block collects up to sixteen interrupt lines, of which lines 4 through 15 are wired to external maskable sources. Each source line passes through its own edge detector. A per-line polarity bit chooses whether the detector reacts to a rising or to a falling transition. A detected edge sets a sticky pending flag. Software reaches four registers through a single address/write/read port:

- the enable register, which also holds a global enable bit and a stored non-maskable enable bit;
- a write-one-to-clear register for pending flags;
- a read-only view of the pending flags;
- the polarity register.

Software changes enables by read-modify-write, so that one line can be switched on or off without disturbing the others.

A small state machine drives the request to the host. In state ST_IDLE it looks for lines that are pending, individually enabled and globally enabled. If there are any, it takes transition T_RAISE into ST_PRESENT and latches the lowest-numbered such line as the presented index. In ST_PRESENT the request stays high and the index is held stable. Two transitions lead back to ST_IDLE:

- T_ACK: the host acknowledges, which clears the presented line's pending flag.
- T_WITHDRAW: the presented line stops being eligible, because its flag was cleared or an enable was removed. The request is dropped in the same cycle the line loses eligibility.

Otherwise the machine stays where it is. After either transition back, ST_IDLE re-evaluates on the next cycle.

Top module: `irq_mask_ctrl`

## Requirements
- R1: After reset, all four registers read zero and `irq_req` is low.
- R2: Address 0 is the enable register. Bit 0 is the global enable, bit 1 the non-maskable enable, and bit n (4..15) the enable of line n. Bits 2 and 3 read as zero and ignore writes.
- R3: Address 3 is the polarity register. Bit n = 0 selects rising edges and bit n = 1 selects falling edges for line n. Bits 0..3 read zero. A selected edge on line n sets bit n of the pending register (address 2) on the next clock. The opposite edge leaves it unchanged.
- R4: Address 1 is the clear register. A write clears exactly the pending bits written as one and leaves bits written as zero untouched. Reading it returns zero.
- R5: When a selected edge and a clear (or acknowledge) hit the same line in the same cycle, the line stays pending.
- R6: A pending line raises `irq_req` only while both its enable bit and the global enable bit are set. Enables never alter the pending flags.
- R7: When several eligible lines are pending at the moment a request is raised, `irq_idx` shows the lowest line number. The index is held while the request is high.
- R8: `irq_ack` while `irq_req` is high clears the pending flag of the presented line. The request then goes low for one cycle, after which the next eligible line is presented.
- R9: Clearing one enable bit by read-modify-write removes a presented request from that line at once. The other enables are unchanged, and the next eligible line is presented two cycles later.
- R10: A selected edge applied before clock edge k sets the pending flag at edge k, and `irq_req` rises at edge k+1.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| line_i | input | 12 | Source lines 15..4 |
| wr_en_i | input | 1 | Register write strobe |
| addr_i | input | 2 | Register address (0 enable, 1 clear, 2 pending, 3 polarity) |
| wdata_i | input | 16 | Write data |
| rdata_o | output | 16 | Read data for `addr_i`, combinational |
| irq_ack_i | input | 1 | Host acknowledge of the presented line |
| irq_req_o | output | 1 | Interrupt request to the host |
| irq_idx_o | output | 4 | Index of the presented line |

## Verification
Edge detection is driven with both polarities, so a missing or inverted polarity select shows up as a flag on the wrong transition. Clears are written with mixed masks, and with a clear that coincides with a fresh edge, which separates a true write-one-to-clear from a whole-register write and exposes which side wins a collision. Three lines are raised together and then acknowledged one by one, which distinguishes lowest-first priority from highest-first and checks the single idle cycle between requests. A read-modify-write disable of the presented line, with the global and per-line enables toggled separately, confirms that a request is withdrawn only by its own gate and that pending flags survive masking.

// File: rtl/icu_pkg.sv
package icu_pkg;
    typedef enum logic [1:0] {
        REG_ENABLE   = 2'd0,
        REG_CLEAR    = 2'd1,
        REG_PENDING  = 2'd2,
        REG_POLARITY = 2'd3
    } icu_reg_e;

    typedef enum logic {
        ST_IDLE    = 1'b0,
        ST_PRESENT = 1'b1
    } icu_state_e;

    localparam int GIE_BIT  = 0;
    localparam int NMIE_BIT = 1;
endpackage

// File: rtl/icu_edge_cell.sv
module icu_edge_cell (
    input  logic clk,
    input  logic rst_n,
    input  logic level_i,
    input  logic fall_sel_i,
    output logic edge_o
);
    logic prev_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) prev_q <= 1'b0;
        else        prev_q <= level_i;
    end

    always_comb begin
        if (fall_sel_i) edge_o = prev_q & ~level_i;
        else            edge_o = level_i & ~prev_q;
    end
endmodule

// File: rtl/icu_pending.sv
module icu_pending #(
    parameter int NUM_LINES = 16
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [NUM_LINES-1:0] edge_i,
    input  logic [NUM_LINES-1:0] clr_mask_i,
    input  logic [NUM_LINES-1:0] ack_mask_i,
    output logic [NUM_LINES-1:0] pend_o
);
    logic [NUM_LINES-1:0] pend_q;
    logic [NUM_LINES-1:0] pend_d;

    always_comb begin
        pend_d = (pend_q & ~(clr_mask_i | ack_mask_i)) | edge_i;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) pend_q <= '0;
        else        pend_q <= pend_d;
    end

    assign pend_o = pend_q;

    AST_EDGE_SETS_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
        (edge_i != '0) |=> ((pend_q & $past(edge_i)) == $past(edge_i))); // R5

    AST_FALL_ONLY_WHEN_CLEARED: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> ((($past(pend_q) & ~pend_q) & ~($past(clr_mask_i) | $past(ack_mask_i))) == '0)); // R4
endmodule

// File: rtl/icu_arbiter.sv
module icu_arbiter
    import icu_pkg::*;
#(
    parameter int NUM_LINES = 16,
    localparam int IDX_W = $clog2(NUM_LINES)
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [NUM_LINES-1:0] elig_i,
    input  logic                 ack_i,
    output logic                 req_o,
    output logic [IDX_W-1:0]     idx_o,
    output logic [NUM_LINES-1:0] ack_mask_o
);
    icu_state_e       state_q, state_d;
    logic [IDX_W-1:0] held_q, held_d;
    logic [IDX_W-1:0] best_idx;
    logic             any_elig;
    logic             held_elig;

    always_comb begin
        best_idx = '0;
        any_elig = 1'b0;
        for (int i = 0; i < NUM_LINES; i++) begin
            if (elig_i[i] && !any_elig) begin
                best_idx = IDX_W'(i);
                any_elig = 1'b1;
            end
        end
    end

    assign held_elig = elig_i[held_q];

    always_comb begin
        state_d = state_q;
        held_d  = held_q;
        unique case (state_q)
            ST_IDLE: begin
                if (any_elig) begin
                    state_d = ST_PRESENT;
                    held_d  = best_idx;
                end
            end
            ST_PRESENT: begin
                if (ack_i || !held_elig) state_d = ST_IDLE;
            end
            default: state_d = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            held_q  <= '0;
        end else begin
            state_q <= state_d;
            held_q  <= held_d;
        end
    end

    always_comb begin
        req_o      = (state_q == ST_PRESENT) && held_elig;
        idx_o      = held_q;
        ack_mask_o = '0;
        for (int i = 0; i < NUM_LINES; i++) begin
            ack_mask_o[i] = req_o && ack_i && (held_q == IDX_W'(i));
        end
    end

    logic [NUM_LINES-1:0] below_mask;
    always_comb begin
        for (int i = 0; i < NUM_LINES; i++) begin
            below_mask[i] = (i < int'(held_q));
        end
    end

    AST_IDX_LOWEST: assert property (@(posedge clk) disable iff (!rst_n)
        ((state_q == ST_PRESENT) && ($past(state_q) == ST_IDLE)) |->
            (($past(elig_i) & below_mask) == '0)); // R7
endmodule

// File: rtl/irq_mask_ctrl.sv
module irq_mask_ctrl
    import icu_pkg::*;
#(
    parameter int NUM_LINES  = 16,
    parameter int FIRST_LINE = 4,
    localparam int IDX_W     = $clog2(NUM_LINES)
) (
    input  logic                            clk,
    input  logic                            rst_n,
    input  logic [NUM_LINES-1:FIRST_LINE]   line_i,
    input  logic                            wr_en_i,
    input  logic [1:0]                      addr_i,
    input  logic [NUM_LINES-1:0]            wdata_i,
    output logic [NUM_LINES-1:0]            rdata_o,
    input  logic                            irq_ack_i,
    output logic                            irq_req_o,
    output logic [IDX_W-1:0]                irq_idx_o
);
    localparam logic [NUM_LINES-1:0] LINE_MASK = {NUM_LINES{1'b1}} << FIRST_LINE;
    localparam logic [NUM_LINES-1:0] EN_WMASK  =
        LINE_MASK | (NUM_LINES'(1) << GIE_BIT) | (NUM_LINES'(1) << NMIE_BIT);

    logic [NUM_LINES-1:0] en_q;
    logic [NUM_LINES-1:0] pol_q;
    logic [NUM_LINES-1:0] edge_vec;
    logic [NUM_LINES-1:0] pend_vec;
    logic [NUM_LINES-1:0] clr_mask;
    logic [NUM_LINES-1:0] ack_mask;
    logic [NUM_LINES-1:0] elig_vec;
    icu_reg_e             reg_sel;

    assign reg_sel = icu_reg_e'(addr_i);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            en_q  <= '0;
            pol_q <= '0;
        end else if (wr_en_i) begin
            if (reg_sel == REG_ENABLE)   en_q  <= wdata_i & EN_WMASK;
            if (reg_sel == REG_POLARITY) pol_q <= wdata_i & LINE_MASK;
        end
    end

    assign clr_mask = (wr_en_i && reg_sel == REG_CLEAR) ? wdata_i : '0;

    genvar g;
    generate
        for (g = 0; g < NUM_LINES; g++) begin : g_line
            if (g >= FIRST_LINE) begin : g_src
                icu_edge_cell u_edge (
                    .clk        (clk),
                    .rst_n      (rst_n),
                    .level_i    (line_i[g]),
                    .fall_sel_i (pol_q[g]),
                    .edge_o     (edge_vec[g])
                );
            end else begin : g_none
                assign edge_vec[g] = 1'b0;
            end
        end
    endgenerate

    icu_pending #(.NUM_LINES(NUM_LINES)) u_pending (
        .clk        (clk),
        .rst_n      (rst_n),
        .edge_i     (edge_vec),
        .clr_mask_i (clr_mask),
        .ack_mask_i (ack_mask),
        .pend_o     (pend_vec)
    );

    assign elig_vec = pend_vec & en_q & LINE_MASK & {NUM_LINES{en_q[GIE_BIT]}};

    icu_arbiter #(.NUM_LINES(NUM_LINES)) u_arbiter (
        .clk        (clk),
        .rst_n      (rst_n),
        .elig_i     (elig_vec),
        .ack_i      (irq_ack_i),
        .req_o      (irq_req_o),
        .idx_o      (irq_idx_o),
        .ack_mask_o (ack_mask)
    );

    always_comb begin
        unique case (reg_sel)
            REG_ENABLE:   rdata_o = en_q;
            REG_CLEAR:    rdata_o = '0;
            REG_PENDING:  rdata_o = pend_vec;
            REG_POLARITY: rdata_o = pol_q;
            default:      rdata_o = '0;
        endcase
    end

    AST_REQ_ELIGIBLE: assert property (@(posedge clk) disable iff (!rst_n)
        irq_req_o |-> (pend_vec[irq_idx_o] && en_q[irq_idx_o] && en_q[GIE_BIT])); // R6

    AST_ACK_DROPS_REQ: assert property (@(posedge clk) disable iff (!rst_n)
        (irq_ack_i && irq_req_o) |=> !irq_req_o); // R8
endmodule

// File: tb/irq_mask_ctrl_test.sv
`timescale 1ns/1ps
module irq_mask_ctrl_test;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [15:4] lines = '0;
    logic        wr_en = 1'b0;
    logic [1:0]  addr = 2'd0;
    logic [15:0] wdata = '0;
    logic [15:0] rdata;
    logic        ack = 1'b0;
    logic        req;
    logic [3:0]  idx;

    int checks = 0;
    int failures = 0;
    bit done = 1'b0;

    always #4 clk = ~clk;

    irq_mask_ctrl uut (
        .clk       (clk),
        .rst_n     (rst_n),
        .line_i    (lines),
        .wr_en_i   (wr_en),
        .addr_i    (addr),
        .wdata_i   (wdata),
        .rdata_o   (rdata),
        .irq_ack_i (ack),
        .irq_req_o (req),
        .irq_idx_o (idx)
    );

    task automatic check(input string tag, input logic [15:0] act, input logic [15:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=0x%04h expected=0x%04h", tag, act, exp);
        end
    endtask

    task automatic write_reg(input logic [1:0] a, input logic [15:0] d);
        @(negedge clk);
        wr_en = 1'b1; addr = a; wdata = d;
        @(negedge clk);
        wr_en = 1'b0; wdata = '0;
    endtask

    task automatic read_reg(input logic [1:0] a, output logic [15:0] d);
        addr = a;
        #1;
        d = rdata;
    endtask

    task automatic cleanup();
        write_reg(2'd0, 16'h0000);
        write_reg(2'd3, 16'h0000);
        lines = '0;
        write_reg(2'd1, 16'hFFFF);
    endtask

    task automatic t_reset();
        logic [15:0] v;
        for (int a = 0; a < 4; a++) begin
            read_reg(a[1:0], v);
            check("R1 register after reset", v, 16'h0000);
        end
        check("R1 request after reset", {15'd0, req}, 16'h0000);
    endtask

    task automatic t_enable_rw();
        logic [15:0] v;
        write_reg(2'd0, 16'hFFFF);
        read_reg(2'd0, v);
        check("R2 enable reserved bits read zero", v, 16'hFFF3);
        write_reg(2'd0, 16'h0006);
        read_reg(2'd0, v);
        check("R2 enable nmie kept, reserved dropped", v, 16'h0002);
        cleanup();
    endtask

    task automatic t_polarity();
        logic [15:0] v;
        lines[9] = 1'b1;
        @(negedge clk);
        read_reg(2'd2, v);
        check("R3 rising edge line 9 pending", v, 16'h0200);
        lines[9] = 1'b0;
        write_reg(2'd1, 16'h0200);
        read_reg(2'd2, v);
        check("R3 falling edge ignored on rising line", v, 16'h0000);
        write_reg(2'd3, 16'h002F);
        read_reg(2'd3, v);
        check("R3 polarity low bits read zero", v, 16'h0020);
        lines[5] = 1'b1;
        @(negedge clk);
        read_reg(2'd2, v);
        check("R3 rising edge ignored on falling line", v, 16'h0000);
        lines[5] = 1'b0;
        @(negedge clk);
        read_reg(2'd2, v);
        check("R3 falling edge line 5 pending", v, 16'h0020);
        cleanup();
    endtask

    task automatic t_clear();
        logic [15:0] v;
        lines[5] = 1'b1; lines[9] = 1'b1; lines[12] = 1'b1;
        @(negedge clk);
        read_reg(2'd2, v);
        check("R4 three lines pending", v, 16'h1220);
        write_reg(2'd1, 16'h0200);
        read_reg(2'd2, v);
        check("R4 w1c clears only line 9", v, 16'h1020);
        read_reg(2'd1, v);
        check("R4 clear register reads zero", v, 16'h0000);
        cleanup();
    endtask

    task automatic t_edge_vs_clear();
        logic [15:0] v;
        @(negedge clk);
        lines[7] = 1'b1;
        wr_en = 1'b1; addr = 2'd1; wdata = 16'h0080;
        @(negedge clk);
        wr_en = 1'b0; wdata = '0;
        read_reg(2'd2, v);
        check("R5 edge wins over same-cycle clear", v, 16'h0080);
        cleanup();
    endtask

    task automatic t_gating();
        logic [15:0] v;
        lines[6] = 1'b1;
        write_reg(2'd0, 16'h0040);
        @(negedge clk); @(negedge clk);
        check("R6 no request without global enable", {15'd0, req}, 16'h0000);
        write_reg(2'd0, 16'h0001);
        @(negedge clk); @(negedge clk);
        check("R6 no request without line enable", {15'd0, req}, 16'h0000);
        read_reg(2'd2, v);
        check("R6 pending kept while masked", v, 16'h0040);
        write_reg(2'd0, 16'h0041);
        @(negedge clk);
        check("R6 request with both enables", {11'd0, idx, req}, 16'h000D);
        cleanup();
    endtask

    task automatic t_priority_ack();
        logic [15:0] v;
        write_reg(2'd0, 16'h4441);
        lines[6] = 1'b1; lines[10] = 1'b1; lines[14] = 1'b1;
        @(negedge clk); @(negedge clk);
        check("R7 lowest line presented", {11'd0, idx, req}, 16'h000D);
        ack = 1'b1;
        @(negedge clk);
        ack = 1'b0;
        check("R8 request low after ack", {15'd0, req}, 16'h0000);
        read_reg(2'd2, v);
        check("R8 ack clears presented flag only", v, 16'h4400);
        @(negedge clk);
        check("R8 next line presented", {11'd0, idx, req}, 16'h0015);
        cleanup();
    endtask

    task automatic t_rmw_disable();
        logic [15:0] v;
        write_reg(2'd0, 16'h4403);
        lines[10] = 1'b1; lines[14] = 1'b1;
        @(negedge clk); @(negedge clk);
        check("R9 line 10 presented", {11'd0, idx, req}, 16'h0015);
        read_reg(2'd0, v);
        write_reg(2'd0, v & 16'hFBFF);
        check("R9 request withdrawn at once", {15'd0, req}, 16'h0000);
        read_reg(2'd0, v);
        check("R9 other enables unchanged", v, 16'h4003);
        @(negedge clk); @(negedge clk);
        check("R9 line 14 presented", {11'd0, idx, req}, 16'h001D);
        read_reg(2'd2, v);
        check("R9 disabled line still pending", v, 16'h4400);
        cleanup();
    endtask

    task automatic t_latency();
        logic [15:0] v;
        write_reg(2'd0, 16'hFFF1);
        lines[11] = 1'b1;
        @(negedge clk);
        read_reg(2'd2, v);
        check("R10 pending after first edge", v, 16'h0800);
        check("R10 request not yet high", {15'd0, req}, 16'h0000);
        @(negedge clk);
        check("R10 request after second edge", {11'd0, idx, req}, 16'h0017);
        cleanup();
    endtask

    initial begin
        #800000;
        if (!done) begin
            checks++;
            failures++;
            $display("FAIL watchdog expired");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        t_reset();
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_enable_rw();
        t_polarity();
        t_clear();
        t_edge_vs_clear();
        t_gating();
        t_priority_ack();
        t_rmw_disable();
        t_latency();
        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule